// File: doc/BRIEF.md
# Latched Low-Battery Alarm Controller

This block watches the gauge's state-of-charge estimate and the measured battery voltage and raises an active-low, open-drain alarm when either one falls below a programmable limit. Each source has a sticky flag. A flag stays set until software clears it, and the pin stays driven while either flag is set.

A source re-arms only after a sample shows its condition gone. Clearing a flag while the battery is still low therefore does not raise it again at once. The condition must disappear and then come back. The other source is not held by this and can still trigger.

A software control bit can force the pin low. Conditions are evaluated only when the measurement side strobes a new sample, so after reset the pin stays released until the first estimate is ready. Thresholds, enable and pin control are held in a small configuration register that is loaded by a write strobe. Register bus decoding sits outside the block.

Top module: `lowbat_alarm`

## Requirements
- R1: After reset both flags read 0 and `alm_drive_low` is 0. The configuration resets to SOC threshold 2, voltage threshold 170, alarm enable 1 and pin-follow 1.
- R2: A cycle with `cfg_we` high loads the four configuration fields. The new values govern every sample from the next cycle on.
- R3: On a sample with enable 1, the SOC flag sets in the cycle after the strobe when `soc_val[15:8]` (0.5 % units) is below the SOC threshold and the SOC source is armed.
- R4: On a sample with enable 1, the voltage flag sets in the cycle after the strobe when `volt_val` is below the voltage threshold times 8 and the voltage source is armed.
- R5: A value equal to its threshold is not low. With the reset thresholds, a SOC high byte of 2 and a voltage of 1360 raise no flag.
- R6: With alarm enable 0, a sample raises no flag. The sample also counts as the condition being absent, so it re-arms the source.
- R7: A set flag stays set after its condition goes away, until its clear strobe arrives. With pin-follow 1, `alm_drive_low` is 1 exactly while at least one flag is set.
- R8: A source disarms when its flag sets. It re-arms on a later sample that shows its condition absent. While disarmed, a low sample does not set its flag, even after a clear.
- R9: While one source is disarmed, the other source can still set its own flag and drive the pin.
- R10: When pin-follow is 0, `alm_drive_low` is 1 whatever the flags are, including before the first sample.
- R11: With `sample_vld` low, changes on `soc_val` or `volt_val` leave both flags unchanged.
- R12: If a clear strobe and a triggering sample arrive in the same cycle for an armed source, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | New SOC/voltage sample strobe |
| soc_val | input | 16 | SOC estimate, 1/512 % per LSB |
| volt_val | input | 16 | Battery voltage, 2.20 mV per LSB |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_alm_en | input | 1 | Alarm enable value to load |
| cfg_pin_follow | input | 1 | 1: pin follows flags, 0: pin forced low |
| cfg_soc_thr | input | 8 | SOC threshold, 0.5 % units |
| cfg_volt_thr | input | 8 | Voltage threshold, 8 voltage LSBs per unit |
| clr_soc_flag | input | 1 | Clear strobe for the SOC flag |
| clr_volt_flag | input | 1 | Clear strobe for the voltage flag |
| alm_drive_low | output | 1 | Enable for the open-drain pull-down |
| flag_soc | output | 1 | Sticky low-SOC flag |
| flag_volt | output | 1 | Sticky low-voltage flag |

## Verification
The arm bits are hidden state. A wrong arm bit shows at the ports on the first low sample after a clear: the flag sets when it should stay clear, or the reverse, one cycle after the strobe. A wrong flag or a wrong configuration field shows on `alm_drive_low` and the flag outputs in the cycle after the sample or write that exposed it. For this reason the bench runs a behavioural model and compares all three outputs on every clock.

// File: rtl/lowbat_alarm.sv
module lowbat_alarm #(
  parameter int SOC_W        = 16,
  parameter int VOLT_W       = 16,
  parameter int THR_W        = 8,
  parameter int VSTEP_LOG2   = 3,
  parameter int SOC_THR_RST  = 2,
  parameter int VOLT_THR_RST = 170
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [SOC_W-1:0]  soc_val,
  input  logic [VOLT_W-1:0] volt_val,
  input  logic              cfg_we,
  input  logic              cfg_alm_en,
  input  logic              cfg_pin_follow,
  input  logic [THR_W-1:0]  cfg_soc_thr,
  input  logic [THR_W-1:0]  cfg_volt_thr,
  input  logic              clr_soc_flag,
  input  logic              clr_volt_flag,
  output logic              alm_drive_low,
  output logic              flag_soc,
  output logic              flag_volt
);
  localparam int VCMP_W = THR_W + VSTEP_LOG2;
  localparam int VPAD   = VOLT_W - VCMP_W;

  logic             en_q, follow_q;
  logic [THR_W-1:0] soc_thr_q, volt_thr_q;
  logic             arm_soc, arm_volt;

  wire [THR_W-1:0]  soc_hi     = soc_val[SOC_W-1 -: THR_W];
  wire [VOLT_W-1:0] volt_limit = {{VPAD{1'b0}}, volt_thr_q, {VSTEP_LOG2{1'b0}}};
  wire              soc_low    = en_q && (soc_hi < soc_thr_q);
  wire              volt_low   = en_q && (volt_val < volt_limit);
  wire              hit_soc    = sample_vld && soc_low && arm_soc;
  wire              hit_volt   = sample_vld && volt_low && arm_volt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b1;
      follow_q   <= 1'b1;
      soc_thr_q  <= THR_W'(SOC_THR_RST);
      volt_thr_q <= THR_W'(VOLT_THR_RST);
    end else if (cfg_we) begin
      en_q       <= cfg_alm_en;
      follow_q   <= cfg_pin_follow;
      soc_thr_q  <= cfg_soc_thr;
      volt_thr_q <= cfg_volt_thr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_soc  <= 1'b1;
      arm_volt <= 1'b1;
    end else if (sample_vld) begin
      if (!soc_low)      arm_soc  <= 1'b1;
      else if (hit_soc)  arm_soc  <= 1'b0;
      if (!volt_low)     arm_volt <= 1'b1;
      else if (hit_volt) arm_volt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_soc  <= 1'b0;
      flag_volt <= 1'b0;
    end else begin
      if (hit_soc)           flag_soc  <= 1'b1;
      else if (clr_soc_flag) flag_soc  <= 1'b0;
      if (hit_volt)           flag_volt <= 1'b1;
      else if (clr_volt_flag) flag_volt <= 1'b0;
    end
  end

  assign alm_drive_low = !follow_q || flag_soc || flag_volt;

  // R3
  soc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_soc) |-> $past(sample_vld) && $past(soc_val[SOC_W-1 -: THR_W] < soc_thr_q));
  // R4
  volt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_volt) |-> $past(sample_vld) && $past(volt_val < volt_limit));
  // R7
  soc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_soc) |-> $past(clr_soc_flag));
  // R7
  volt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_volt) |-> $past(clr_volt_flag));
  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !cfg_we |=> !$rose(flag_soc) && !$rose(flag_volt));
  // R11
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !$rose(flag_soc) && !$rose(flag_volt));
endmodule

// File: tb/sim_lowbat_alarm.sv
`timescale 1ns/1ps
module sim_lowbat_alarm;
  logic clk = 0, rst_n = 0;
  logic sample_vld = 0, cfg_we = 0, cfg_alm_en = 1, cfg_pin_follow = 1;
  logic [15:0] soc_val = 16'hFFFF, volt_val = 16'hFFFF;
  logic [7:0] cfg_soc_thr = 2, cfg_volt_thr = 170;
  logic clr_soc_flag = 0, clr_volt_flag = 0;
  logic alm_drive_low, flag_soc, flag_volt;

  lowbat_alarm u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit m_en = 1, m_follow = 1, m_fs = 0, m_fv = 0, m_as = 1, m_av = 1;
  int m_sthr = 2, m_vthr = 170;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1; m_follow = 1; m_fs = 0; m_fv = 0; m_as = 1; m_av = 1;
      m_sthr = 2; m_vthr = 170;
    end else begin
      bit sl, vl, ns, nv;
      sl = m_en && (int'(soc_val) / 256 < m_sthr);
      vl = m_en && (int'(volt_val) < m_vthr * 8);
      ns = m_fs; nv = m_fv;
      if (clr_soc_flag) ns = 0;
      if (clr_volt_flag) nv = 0;
      if (sample_vld) begin
        if (sl && m_as) begin ns = 1; m_as = 0; end
        else if (!sl) m_as = 1;
        if (vl && m_av) begin nv = 1; m_av = 0; end
        else if (!vl) m_av = 1;
      end
      m_fs = ns; m_fv = nv;
      if (cfg_we) begin
        m_en = cfg_alm_en; m_follow = cfg_pin_follow;
        m_sthr = cfg_soc_thr; m_vthr = cfg_volt_thr;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit ed;
      ed = !m_follow || m_fs || m_fv;
      checks++;
      if (flag_soc !== m_fs || flag_volt !== m_fv || alm_drive_low !== ed) begin
        failures++;
        $display("FAIL R7 model: got soc=%b volt=%b pin=%b exp soc=%b volt=%b pin=%b",
                 flag_soc, flag_volt, alm_drive_low, m_fs, m_fv, ed);
      end
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, bit s, bit v, bit p);
    checks++;
    if (flag_soc !== s || flag_volt !== v || alm_drive_low !== p) begin
      failures++;
      $display("FAIL %s: got soc=%b volt=%b pin=%b exp soc=%b volt=%b pin=%b",
               tag, flag_soc, flag_volt, alm_drive_low, s, v, p);
    end
  endtask

  task automatic smp(int soc_hi, int volt, bit cs = 0, bit cv = 0);
    @(negedge clk);
    soc_val = 16'(soc_hi * 256 + 8'h80); volt_val = 16'(volt);
    sample_vld = 1; clr_soc_flag = cs; clr_volt_flag = cv;
    @(negedge clk);
    sample_vld = 0; clr_soc_flag = 0; clr_volt_flag = 0;
  endtask

  task automatic clr(bit cs, bit cv);
    @(negedge clk);
    clr_soc_flag = cs; clr_volt_flag = cv;
    @(negedge clk);
    clr_soc_flag = 0; clr_volt_flag = 0;
  endtask

  task automatic cfg(bit en, bit fol, int st, int vt);
    @(negedge clk);
    cfg_we = 1; cfg_alm_en = en; cfg_pin_follow = fol;
    cfg_soc_thr = 8'(st); cfg_volt_thr = 8'(vt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", 0, 0, 0);
    // R11: inputs move without strobe
    soc_val = 0; volt_val = 0;
    repeat (3) @(negedge clk);
    chk("R11 no strobe", 0, 0, 0);
    smp(2, 1360);
    chk("R5 equal thresholds", 0, 0, 0);
    smp(1, 4000);
    chk("R3 low soc", 1, 0, 1);
    smp(50, 4000);
    chk("R7 sticky after recovery", 1, 0, 1);
    clr(1, 0);
    chk("R7 cleared", 0, 0, 0);
    smp(0, 4000);
    chk("R3 second trigger", 1, 0, 1);
    clr(1, 0);
    smp(0, 4000);
    chk("R8 no retrigger while low", 0, 0, 0);
    smp(0, 1359);
    chk("R9 other source triggers", 0, 1, 1);
    chk("R4 low volt", 0, 1, 1);
    smp(50, 4000);
    smp(0, 1000);
    chk("R8 rearmed both", 1, 1, 1);
    clr(1, 0);
    chk("R7 pin held by remaining flag", 0, 1, 1);
    clr(0, 1);
    chk("R7 both cleared", 0, 0, 0);
    smp(50, 4000);
    cfg(0, 1, 2, 170);
    smp(0, 0);
    chk("R6 disabled", 0, 0, 0);
    cfg(1, 1, 50, 200);
    smp(50, 1600);
    chk("R2 new thresholds boundary", 0, 0, 0);
    smp(49, 1599);
    chk("R2 new thresholds low", 1, 1, 1);
    clr(1, 1);
    smp(60, 3000);
    smp(10, 3000, 1, 0);
    chk("R12 clear and trigger", 1, 0, 1);
    clr(1, 0);
    cfg(1, 0, 50, 200);
    chk("R10 force low", 0, 0, 1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cfg(1, 0, 2, 170);
    chk("R10 force low before first sample", 0, 0, 1);
    cfg(1, 1, 2, 170);
    chk("R1 released again", 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule